// File: doc/BRIEF.md
# Vector complex add with rotate

This block takes two 128-bit source vectors and treats each adjacent pair of lanes as one complex number, with the even lane as the real part and the odd lane as the imaginary part. It adds the first source to the second source after rotating the second by 90 or 270 degrees in the complex plane. Each lane is therefore paired with the neighbouring lane of the other operand, and it adds or subtracts depending on its parity and on the rotation. Lanes are 8, 16 or 32 bits wide, so the vector holds 16, 8 or 4 of them.

The lane results are merged byte by byte into the previous destination value under a 16-bit byte-enable mask, and the merged vector is registered. It appears on the output one clock after the operands are presented. Every lane result is built from the source values as presented, so a destination that aliases a source gives the same result. The size code 2'b11 does not denote a lane width for this operation. It raises an invalid flag and passes the previous destination through unchanged.

Top module: `cplx_rot_add`

## Requirements
- R1: While rst_n is low, and after it rises but before the first operand edge, dst_out is all zeros and bad_size is 0.
- R2: Lane e occupies bits [e*W +: W] of each vector, with lane 0 at the least significant end. lane_sz 0, 1 and 2 select W = 8, 16 and 32, which gives 16, 8 and 4 lanes.
- R3: With rot_sel = 0 (90 degrees), an even lane e yields src_a[e] - src_b[e+1] and an odd lane e yields src_a[e] + src_b[e-1].
- R4: With rot_sel = 1 (270 degrees), an even lane e yields src_a[e] + src_b[e+1] and an odd lane e yields src_a[e] - src_b[e-1].
- R5: Sums and differences wrap modulo 2^W. There is no saturation and no carry output.
- R6: For each byte i, byte_en[i] = 1 takes result byte i and byte_en[i] = 0 keeps byte i of dst_old. A lane of W bits uses W/8 consecutive mask bits.
- R7: lane_sz = 2'b11 sets bad_size to 1 and makes dst_out equal dst_old, whatever the byte enables are. Valid sizes give bad_size = 0.
- R8: Results depend only on the presented src_a and src_b, including when dst_old carries the same value as a source.
- R9: dst_out and bad_size change only on a rising clock edge and reflect the inputs sampled at that edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 128 | First source vector (unrotated operand) |
| src_b | input | 128 | Second source vector (rotated operand) |
| dst_old | input | 128 | Previous destination value used for merging |
| lane_sz | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = invalid |
| rot_sel | input | 1 | Rotation: 0 = 90 degrees, 1 = 270 degrees |
| byte_en | input | 16 | Per-byte merge enable |
| dst_out | output | 128 | Registered merged destination |
| bad_size | output | 1 | Registered invalid-size flag |

## Verification
On every cycle the assertions check four things: the invalid flag follows the size code, an invalid size or an all-zero enable mask passes the old destination through, the paired lanes add or subtract with the operator that parity and rotation select, and lane 0 of the 8-bit 90-degree case yields the expected difference. Several behaviours come only from the bench's scenarios, checked against an independent reference model. These are the full lane pairing at all three widths, wraparound at the lane boundary, partial byte masks that split a lane, destination aliasing, and the fact that the output holds steady between edges.

// File: rtl/cadd_pkg.sv
package cadd_pkg;

  localparam int VEC_W     = 128;
  localparam int VEC_BYTES = VEC_W / 8;
  localparam int ARITH_W   = 32;

  typedef enum logic [1:0] {
    LANE8    = 2'd0,
    LANE16   = 2'd1,
    LANE32   = 2'd2,
    LANE_BAD = 2'd3
  } lane_size_e;

  // Wrapping add or subtract at the widest lane width; callers truncate.
  function automatic logic [ARITH_W-1:0] addsub(input logic [ARITH_W-1:0] x,
                                                input logic [ARITH_W-1:0] y,
                                                input logic               sub);
    return sub ? (x - y) : (x + y);
  endfunction

  // Even lanes subtract under 90 degrees; odd lanes subtract under 270.
  function automatic logic lane_subtracts(input logic odd_lane, input logic rot270);
    return odd_lane ? rot270 : ~rot270;
  endfunction

endpackage

// File: rtl/cadd_lanes.sv
module cadd_lanes
  import cadd_pkg::*;
#(
  parameter int VW     = 128,
  parameter int LANE_W = 8
) (
  input  logic [VW-1:0]          a_vec,
  input  logic [VW-1:0]          b_vec,
  input  logic                   rot270,
  output logic [VW-1:0]          res_vec,
  output logic [VW/LANE_W-1:0]   sub_flags
);
  localparam int LANES = VW / LANE_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    localparam int  PARTNER = (e % 2 == 0) ? e + 1 : e - 1;
    localparam bit  ODD     = (e % 2 == 1);
    logic [ARITH_W-1:0] opa, opb, full;
    logic               sub;

    assign opa  = ARITH_W'(a_vec[e*LANE_W +: LANE_W]);
    assign opb  = ARITH_W'(b_vec[PARTNER*LANE_W +: LANE_W]);
    assign sub  = lane_subtracts(ODD, rot270);
    assign full = addsub(opa, opb, sub);
    assign res_vec[e*LANE_W +: LANE_W] = full[LANE_W-1:0];
    assign sub_flags[e] = sub;
  end

endmodule

// File: rtl/cadd_merge.sv
module cadd_merge #(
  parameter int VW = 128
) (
  input  logic [VW-1:0]   new_vec,
  input  logic [VW-1:0]   old_vec,
  input  logic [VW/8-1:0] en,
  input  logic            apply,
  output logic [VW-1:0]   merged
);
  localparam int NB = VW / 8;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign merged[i*8 +: 8] = (apply && en[i]) ? new_vec[i*8 +: 8] : old_vec[i*8 +: 8];
  end

endmodule

// File: rtl/cplx_rot_add.sv
module cplx_rot_add
  import cadd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [VEC_W-1:0]     src_a,
  input  logic [VEC_W-1:0]     src_b,
  input  logic [VEC_W-1:0]     dst_old,
  input  logic [1:0]           lane_sz,
  input  logic                 rot_sel,
  input  logic [VEC_BYTES-1:0] byte_en,
  output logic [VEC_W-1:0]     dst_out,
  output logic                 bad_size
);
  localparam int NSIZES = 3;

  logic [VEC_W-1:0] res_by_size [NSIZES];
  logic [VEC_W/8-1:0] subs8;
  logic [VEC_W/16-1:0] subs16;
  logic [VEC_W/32-1:0] subs32;

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    logic [VEC_W/LW-1:0] sf;
    cadd_lanes #(.VW(VEC_W), .LANE_W(LW)) u_lanes (
      .a_vec    (src_a),
      .b_vec    (src_b),
      .rot270   (rot_sel),
      .res_vec  (res_by_size[s]),
      .sub_flags(sf)
    );
  end

  assign subs8  = g_size[0].sf;
  assign subs16 = g_size[1].sf;
  assign subs32 = g_size[2].sf;

  lane_size_e       size_e;
  logic             size_bad;
  logic [VEC_W-1:0] lane_result;
  logic [VEC_W-1:0] merged_next;

  assign size_e   = lane_size_e'(lane_sz);
  assign size_bad = (size_e == LANE_BAD);

  always_comb begin
    case (size_e)
      LANE8:   lane_result = res_by_size[0];
      LANE16:  lane_result = res_by_size[1];
      LANE32:  lane_result = res_by_size[2];
      default: lane_result = dst_old;
    endcase
  end

  cadd_merge #(.VW(VEC_W)) u_merge (
    .new_vec(lane_result),
    .old_vec(dst_old),
    .en     (byte_en),
    .apply  (~size_bad),
    .merged (merged_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_out  <= '0;
      bad_size <= 1'b0;
    end else begin
      dst_out  <= merged_next;
      bad_size <= size_bad;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (bad_size == ($past(lane_sz) == 2'b11)));

  // R7
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && bad_size) |-> (dst_out == $past(dst_old)));

  // R6
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(byte_en) == '0) |-> (dst_out == $past(dst_old)));

  // R3 R4
  pair_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (subs8[0] != subs8[1]) && (subs16[0] != subs16[1]) && (subs32[2] != subs32[3])
    && (subs8[0] == subs32[0]) && (subs16[1] == subs8[1]));

  // R3
  lane0_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(lane_sz) == 2'b00 && !$past(rot_sel) && $past(byte_en[0]))
    |-> (dst_out[7:0] == 8'($past(src_a[7:0]) - $past(src_b[15:8]))));

endmodule

// File: tb/tb_cplx_rot_add.sv
`timescale 1ns/1ps
module tb_cplx_rot_add;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [1:0]   lane_sz = 2'd0;
  logic         rot_sel = 1'b0;
  logic [15:0]  byte_en = '0;
  logic [127:0] dst_out;
  logic         bad_size;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cplx_rot_add dut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .lane_sz(lane_sz), .rot_sel(rot_sel), .byte_en(byte_en),
    .dst_out(dst_out), .bad_size(bad_size)
  );

  function automatic logic [127:0] ref_model(input logic [127:0] a, input logic [127:0] b,
                                             input logic [127:0] old, input logic [1:0] sz,
                                             input logic rot, input logic [15:0] en);
    logic [127:0] r;
    int nb;
    r = old;
    if (sz == 2'b11) return old;
    nb = 1 << sz;
    for (int e = 0; e < 16 / nb; e++) begin
      logic [31:0] x, y, z;
      int p;
      x = '0; y = '0;
      p = e ^ 1;
      for (int k = 0; k < nb; k++) begin
        x[8*k +: 8] = a[8*(e*nb+k) +: 8];
        y[8*k +: 8] = b[8*(p*nb+k) +: 8];
      end
      z = ((e & 1) == int'(rot)) ? x - y : x + y;
      for (int k = 0; k < nb; k++)
        if (en[e*nb+k]) r[8*(e*nb+k) +: 8] = z[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                     input logic [127:0] old, input logic [1:0] sz, input logic rot,
                     input logic [15:0] en, input bit check_hold);
    logic [127:0] prev;
    @(negedge clk);
    prev = dst_out;
    src_a = a; src_b = b; dst_old = old; lane_sz = sz; rot_sel = rot; byte_en = en;
    #1;
    if (check_hold) check_vec({"R9 hold before edge ", tag}, dst_out, prev);
    @(posedge clk);
    #1;
    check_vec(tag, dst_out, ref_model(a, b, old, sz, rot, en));
    check_bit({"R7 flag ", tag}, bad_size, sz == 2'b11);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    logic [127:0] a, b, o;
    void'($urandom(32'd20240601));
    repeat (3) @(posedge clk);
    #1;
    check_vec("R1 reset dst_out", dst_out, '0);
    check_bit("R1 reset bad_size", bad_size, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_vec("R1 after release dst_out", dst_out, '0);

    // R2: 32-bit lane 0 = 5 - 3 at the low end
    a = '0; b = '0; a[31:0] = 32'd5; b[63:32] = 32'd3;
    run("R2 lane0 low bits 32b", a, b, rnd128(), 2'd2, 1'b0, 16'hFFFF, 1'b1);
    check_vec("R2 lane0 value", {96'd0, dst_out[31:0]}, {96'd0, 32'd2});
    // R3 / R4 per size
    for (int s = 0; s < 3; s++) begin
      run("R3 rot90 all bytes", rnd128(), rnd128(), rnd128(), 2'(s), 1'b0, 16'hFFFF, 1'b1);
      run("R4 rot270 all bytes", rnd128(), rnd128(), rnd128(), 2'(s), 1'b1, 16'hFFFF, 1'b1);
    end
    // R5 wrap
    run("R5 wrap 8b", {16{8'hFF}}, {16{8'h01}}, '0, 2'd0, 1'b1, 16'hFFFF, 1'b1);
    check_vec("R5 wrap 8b pattern", dst_out, {8{8'hFE, 8'h00}});
    run("R5 wrap 32b", {4{32'h8000_0000}}, {4{32'h8000_0001}}, '0, 2'd2, 1'b0, 16'hFFFF, 1'b1);
    run("R5 wrap 16b", {8{16'hFFFF}}, {8{16'hFFFF}}, '0, 2'd1, 1'b1, 16'hFFFF, 1'b1);
    // R6 masks
    run("R6 mask zero", rnd128(), rnd128(), rnd128(), 2'd1, 1'b0, 16'h0000, 1'b1);
    run("R6 mask split lane", rnd128(), rnd128(), rnd128(), 2'd2, 1'b1, 16'h0F36, 1'b1);
    run("R6 mask alt bytes", rnd128(), rnd128(), rnd128(), 2'd1, 1'b0, 16'hA5C3, 1'b1);
    // R7 invalid size
    o = rnd128();
    run("R7 bad size full mask", rnd128(), rnd128(), o, 2'd3, 1'b0, 16'hFFFF, 1'b1);
    check_vec("R7 dst unchanged", dst_out, o);
    run("R7 bad size rot270", rnd128(), rnd128(), rnd128(), 2'd3, 1'b1, 16'h1234, 1'b1);
    // R8 aliasing
    a = rnd128(); b = rnd128();
    run("R8 old aliases src_b", a, b, b, 2'd2, 1'b0, 16'hFFFF, 1'b1);
    run("R8 old aliases src_a", a, b, a, 2'd0, 1'b1, 16'h7FFE, 1'b1);
    run("R8 a equals b", a, a, a, 2'd1, 1'b0, 16'hFFFF, 1'b1);
    // random mix: R3 R4 R6 R9
    for (int i = 0; i < 300; i++)
      run("R3/R4/R6 random", rnd128(), rnd128(), rnd128(), 2'($urandom_range(0, 3)),
          1'($urandom()), 16'($urandom()), 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule